// File: doc/BRIEF.md
# Serial Message Framing Controller

This block sequences complete messages for a byte-oriented serial transceiver. A transmit request, or a start bit detected on the line by the external serializer, opens a message. The controller then counts data bytes. The count comes either from a fixed length picked by a 2-bit code or, in variable-length operation, from a leading format byte. Each data byte is marked by a one-cycle transfer strobe toward the 8-bit parallel bus. After the data bytes, the controller hands the line to the redundancy phase, which lasts one or two bytes, and then closes the message. On received messages it flags a message that ends too soon or that runs past its expected length.

The serializer, the check-sum arithmetic and the bit-timing checks are outside this block. The serializer reports each byte boundary with a one-cycle pulse, together with the byte just moved. It reports the end of an incoming message with a separate one-cycle pulse. A 3-bit mode input selects one of three uses: receive, transmit, or a status view in which the error flags sit on the parallel bus.

Top module: `msg_frame_ctrl`

## Requirements
- R1: After reset, `busy`, `data_strobe` and `err` are low, and `bus_oe` is low in any mode other than status mode.
- R2: Length code 2'b11 frames 6 data bytes, 2'b01 frames 4, and 2'b10 frames 2. Each of these data bytes gives exactly one `data_strobe` pulse.
- R3: With length code 2'b00, the first byte of the message is a format byte. It also gives a strobe, and bits [2:0] of it set the number of data bytes that follow, which may be zero.
- R4: `data_strobe` is a single-cycle pulse in the cycle after each `byte_done` of the format or data phase. Redundancy bytes and bytes outside a message give no strobe.
- R5: `busy` rises in the cycle after an accepted start. It stays high for the whole message, through the final redundancy byte when transmitting and until `line_end` when receiving.
- R6: The redundancy phase lasts 1 byte when `hd_long` is 0 and 2 bytes when `hd_long` is 1.
- R7: A `start_req` made while `busy` is high is ignored. The message in progress keeps its length.
- R8: The mode field is `op_mode` = {rx, tx, async}. `start_req` opens a message only when rx=0 and tx=1. `rx_start_det` opens one only when rx=1, which includes 3'b111, receive with regeneration. In modes 3'b000 and 3'b001 nothing starts.
- R9: During a received message, a `line_end` before the last redundancy byte ends the message and raises `err` (status bit 0).
- R10: During a received message, a `byte_done` after the last redundancy byte and before `line_end` raises `err` (status bit 1) and gives no strobe.
- R11: In mode 3'b000, `bus_oe` is high and `bus_out` is the status byte. Bit 0 is the early-end flag, bit 1 is the over-length flag, and the remaining bits are zero.
- R12: While receiving, `bus_oe` is high during each strobe and `bus_out` carries the byte that was strobed. While transmitting, `bus_oe` stays low.
- R13: Error flags are cleared when the next message starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 3 | Mode field {rx, tx, async} |
| len_code | input | 2 | Message length code |
| hd_long | input | 1 | Selects the 2-byte redundancy phase |
| start_req | input | 1 | Transmit start request |
| rx_start_det | input | 1 | Start bit detected by the serializer |
| byte_done | input | 1 | Byte boundary pulse from the serializer |
| byte_in | input | 8 | Byte just transferred |
| line_end | input | 1 | End of the incoming message |
| busy | output | 1 | Message in progress |
| data_strobe | output | 1 | Byte transfer pulse |
| err | output | 1 | Format error seen on the last received message |
| bus_out | output | 8 | Parallel bus output data |
| bus_oe | output | 1 | Parallel bus output enable |

## Verification
The bench builds the block with its default parameters: fixed lengths of 6, 4 and 2 bytes, a 3-bit format count, and redundancy phases of 1 and 2 bytes. With these values every length code, a format byte that announces zero data bytes, and both redundancy lengths all fit in short messages. Early-end and over-length errors are both forced within a few cycles, and each is followed by the error clear at the next start.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FMT  = 3'd1,
    ST_DATA = 3'd2,
    ST_RED  = 3'd3,
    ST_TAIL = 3'd4
  } mfc_state_e;

  function automatic int unsigned max3(input int unsigned a, b, c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/mfc_mode_dec.sv
module mfc_mode_dec (
  input  logic [2:0] op_mode,
  output logic       is_status,
  output logic       rx_sel,
  output logic       tx_sel
);
  // op_mode = {rx, tx, async}
  always_comb begin
    rx_sel    = op_mode[2];
    tx_sel    = !op_mode[2] && op_mode[1];
    is_status = (op_mode == 3'b000);
  end
endmodule

// File: rtl/mfc_len_sel.sv
module mfc_len_sel #(
  parameter int BYTE_W    = 8,
  parameter int CNT_W     = 3,
  parameter int LEN_C3    = 6,
  parameter int LEN_C1    = 4,
  parameter int LEN_C2    = 2,
  parameter int FMT_BITS  = 3,
  parameter int RED_SHORT = 1,
  parameter int RED_LONG  = 2
) (
  input  logic [1:0]        len_code,
  input  logic [BYTE_W-1:0] fmt_byte,
  input  logic              hd_long,
  output logic              var_len,
  output logic [CNT_W-1:0]  fixed_len,
  output logic [CNT_W-1:0]  fmt_len,
  output logic [CNT_W-1:0]  red_len
);
  always_comb begin
    var_len = (len_code == 2'b00);
    unique case (len_code)
      2'b11:   fixed_len = CNT_W'(LEN_C3);
      2'b01:   fixed_len = CNT_W'(LEN_C1);
      2'b10:   fixed_len = CNT_W'(LEN_C2);
      default: fixed_len = '0;
    endcase
    fmt_len = CNT_W'(fmt_byte[FMT_BITS-1:0]);
    red_len = hd_long ? CNT_W'(RED_LONG) : CNT_W'(RED_SHORT);
  end
endmodule

// File: rtl/mfc_byte_cnt.sv
module mfc_byte_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = load_val;
    else if (dec && cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/mfc_err_track.sv
module mfc_err_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set_short,
  input  logic set_long,
  output logic short_q,
  output logic long_q
);
  logic short_d, long_d;

  always_comb begin
    short_d = clr ? 1'b0 : (short_q | set_short);
    long_d  = clr ? 1'b0 : (long_q  | set_long);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_q <= 1'b0;
      long_q  <= 1'b0;
    end else begin
      short_q <= short_d;
      long_q  <= long_d;
    end
  end
endmodule

// File: rtl/msg_frame_ctrl.sv
module msg_frame_ctrl #(
  parameter int BYTE_W      = 8,
  parameter int LEN_C3      = 6,
  parameter int LEN_C1      = 4,
  parameter int LEN_C2      = 2,
  parameter int FMT_BITS    = 3,
  parameter int RED_SHORT   = 1,
  parameter int RED_LONG    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_mode,
  input  logic [1:0]        len_code,
  input  logic              hd_long,
  input  logic              start_req,
  input  logic              rx_start_det,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              line_end,
  output logic              busy,
  output logic              data_strobe,
  output logic              err,
  output logic [BYTE_W-1:0] bus_out,
  output logic              bus_oe
);
  import mfc_pkg::*;

  localparam int MAX_FIX = mfc_pkg::max3(LEN_C3, LEN_C1, LEN_C2);
  localparam int MAX_LEN = mfc_pkg::max3(MAX_FIX, (1 << FMT_BITS) - 1, RED_LONG);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  // reset: asserted asynchronously, released through a synchronizer
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[SYNC_STAGES-1];

  // mode and length selection
  logic is_status, rx_sel, tx_sel;
  logic var_len;
  logic [CNT_W-1:0] fixed_len, fmt_len, red_len;

  mfc_mode_dec u_mode (
    .op_mode   (op_mode),
    .is_status (is_status),
    .rx_sel    (rx_sel),
    .tx_sel    (tx_sel)
  );

  mfc_len_sel #(
    .BYTE_W(BYTE_W), .CNT_W(CNT_W), .LEN_C3(LEN_C3), .LEN_C1(LEN_C1),
    .LEN_C2(LEN_C2), .FMT_BITS(FMT_BITS), .RED_SHORT(RED_SHORT), .RED_LONG(RED_LONG)
  ) u_len (
    .len_code  (len_code),
    .fmt_byte  (byte_in),
    .hd_long   (hd_long),
    .var_len   (var_len),
    .fixed_len (fixed_len),
    .fmt_len   (fmt_len),
    .red_len   (red_len)
  );

  // sequencing state
  mfc_state_e       state_q, state_d;
  logic             dir_rx_q, dir_rx_d;
  logic             strobe_q, strobe_d;
  logic [BYTE_W-1:0] bus_q;
  logic             cap_byte;
  logic             cnt_load, cnt_dec, cnt_last;
  logic [CNT_W-1:0] cnt_val;
  logic             err_clr, set_short, set_long;
  logic             short_q, long_q;
  logic             tx_go, rx_go, early_end;

  mfc_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .last     (cnt_last)
  );

  mfc_err_track u_err (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .clr       (err_clr),
    .set_short (set_short),
    .set_long  (set_long),
    .short_q   (short_q),
    .long_q    (long_q)
  );

  always_comb begin
    tx_go     = tx_sel && start_req;
    rx_go     = rx_sel && rx_start_det;
    early_end = dir_rx_q && line_end;

    state_d   = state_q;
    dir_rx_d  = dir_rx_q;
    strobe_d  = 1'b0;
    cap_byte  = 1'b0;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    cnt_dec   = 1'b0;
    err_clr   = 1'b0;
    set_short = 1'b0;
    set_long  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (tx_go || rx_go) begin
          dir_rx_d = rx_go;
          err_clr  = 1'b1;
          if (var_len) begin
            state_d = ST_FMT;
          end else begin
            state_d  = ST_DATA;
            cnt_load = 1'b1;
            cnt_val  = fixed_len;
          end
        end
      end
      ST_FMT: begin
        if (early_end) begin
          set_short = 1'b1;
          state_d   = ST_IDLE;
        end else if (byte_done) begin
          strobe_d = 1'b1;
          cap_byte = dir_rx_q;
          cnt_load = 1'b1;
          if (fmt_len == '0) begin
            cnt_val = red_len;
            state_d = ST_RED;
          end else begin
            cnt_val = fmt_len;
            state_d = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (early_end) begin
          set_short = 1'b1;
          state_d   = ST_IDLE;
        end else if (byte_done) begin
          strobe_d = 1'b1;
          cap_byte = dir_rx_q;
          if (cnt_last) begin
            cnt_load = 1'b1;
            cnt_val  = red_len;
            state_d  = ST_RED;
          end else begin
            cnt_dec = 1'b1;
          end
        end
      end
      ST_RED: begin
        if (early_end) begin
          set_short = 1'b1;
          state_d   = ST_IDLE;
        end else if (byte_done) begin
          if (cnt_last) state_d = dir_rx_q ? ST_TAIL : ST_IDLE;
          else          cnt_dec = 1'b1;
        end
      end
      ST_TAIL: begin
        if (byte_done) set_long = 1'b1;
        if (line_end)  state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q  <= ST_IDLE;
      dir_rx_q <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      dir_rx_q <= dir_rx_d;
      strobe_q <= strobe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)      bus_q <= '0;
    else if (cap_byte) bus_q <= byte_in;
  end

  logic [BYTE_W-1:0] status_byte;
  always_comb begin
    status_byte    = '0;
    status_byte[0] = short_q;
    status_byte[1] = long_q;
  end

  assign busy        = (state_q != ST_IDLE);
  assign data_strobe = strobe_q;
  assign err         = short_q | long_q;
  assign bus_oe      = is_status | (dir_rx_q & strobe_q);
  assign bus_out     = is_status ? status_byte : bus_q;
endmodule

// File: rtl/msg_frame_ctrl_chk.sv
module msg_frame_ctrl_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_mode,
  input logic              start_req,
  input logic              rx_start_det,
  input logic              byte_done,
  input logic              line_end,
  input logic              busy,
  input logic              data_strobe,
  input logic              err,
  input logic [BYTE_W-1:0] bus_out,
  input logic              bus_oe
);
  assert_strobe_follows_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_strobe |-> $past(byte_done));

  assert_no_strobe_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !data_strobe);

  assert_busy_needs_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req || rx_start_det));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req && !byte_done && !line_end) |=> busy);

  assert_status_on_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 3'b000) |-> (bus_oe && (bus_out >> 2) == '0));

  assert_drive_only_on_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && op_mode != 3'b000) |-> data_strobe);

  assert_err_clear_at_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !err);
endmodule

bind msg_frame_ctrl msg_frame_ctrl_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_mode      (op_mode),
  .start_req    (start_req),
  .rx_start_det (rx_start_det),
  .byte_done    (byte_done),
  .line_end     (line_end),
  .busy         (busy),
  .data_strobe  (data_strobe),
  .err          (err),
  .bus_out      (bus_out),
  .bus_oe       (bus_oe)
);

// File: tb/msg_frame_ctrl_bench.sv
module msg_frame_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op_mode;
  logic [1:0] len_code;
  logic       hd_long, start_req, rx_start_det, byte_done, line_end;
  logic [7:0] byte_in;
  logic       busy, data_strobe, err, bus_oe;
  logic [7:0] bus_out;

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q[$];   // {is_rx, byte}

  always #2.5 clk = ~clk;  // 200 MHz

  msg_frame_ctrl u_msg_frame_ctrl (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .len_code(len_code),
    .hd_long(hd_long), .start_req(start_req), .rx_start_det(rx_start_det),
    .byte_done(byte_done), .byte_in(byte_in), .line_end(line_end),
    .busy(busy), .data_strobe(data_strobe), .err(err),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per observed strobe
  always @(negedge clk) begin
    if (rst_n && data_strobe) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected strobe", 32'd1, 32'd0);
      end else begin
        logic [8:0] it;
        it = exp_q.pop_front();
        if (it[8]) begin
          chk(bus_oe === 1'b1, "R12 rx bus_oe", bus_oe, 1);
          chk(bus_out === it[7:0], "R12 rx bus_out", bus_out, it[7:0]);
        end else begin
          chk(bus_oe === 1'b0, "R12 tx bus_oe", bus_oe, 0);
        end
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic pulse_rxdet();
    @(negedge clk) rx_start_det = 1'b1;
    @(negedge clk) rx_start_det = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk) line_end = 1'b1;
    @(negedge clk) line_end = 1'b0;
  endtask

  task automatic send_data(input logic [7:0] b, input bit rx);
    exp_q.push_back({rx, b});
    @(negedge clk) begin byte_done = 1'b1; byte_in = b; end
    @(negedge clk) byte_done = 1'b0;
  endtask

  task automatic send_red();
    @(negedge clk) begin byte_done = 1'b1; byte_in = 8'h5A; end
    @(negedge clk) byte_done = 1'b0;
  endtask

  task automatic chk_drained(input string req);
    @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R5 watchdog expired", 20000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_mode = 3'b010; len_code = 2'b11; hd_long = 1'b0;
    start_req = 1'b0; rx_start_det = 1'b0; byte_done = 1'b0;
    line_end = 1'b0; byte_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(data_strobe === 1'b0, "R1 strobe", data_strobe, 0);
    chk(err === 1'b0, "R1 err", err, 0);
    chk(bus_oe === 1'b0, "R1 bus_oe", bus_oe, 0);

    // R2 R6 R7: transmit, code 11, short redundancy, ignored restart
    pulse_start();
    chk(busy === 1'b1, "R5 busy after start", busy, 1);
    send_data(8'h11, 0); send_data(8'h12, 0);
    pulse_start();
    chk(busy === 1'b1, "R7 busy after ignored start", busy, 1);
    for (int i = 0; i < 4; i++) send_data(8'h20 + 8'(i), 0);
    chk(busy === 1'b1, "R6 busy before redundancy", busy, 1);
    send_red();
    chk(busy === 1'b0, "R7 R2 message ends after 6 bytes", busy, 0);
    chk_drained("R2 code 11 strobes");

    // R2 R6: transmit, code 01, long redundancy
    len_code = 2'b01; hd_long = 1'b1;
    pulse_start();
    for (int i = 0; i < 4; i++) send_data(8'h30 + 8'(i), 0);
    send_red();
    chk(busy === 1'b1, "R6 busy after first redundancy byte", busy, 1);
    send_red();
    chk(busy === 1'b0, "R6 busy after second redundancy byte", busy, 0);
    chk_drained("R2 code 01 strobes");

    // R2 R12 R5: receive async, code 10
    op_mode = 3'b101; len_code = 2'b10; hd_long = 1'b0;
    pulse_rxdet();
    chk(busy === 1'b1, "R5 busy after rx start", busy, 1);
    send_data(8'hA5, 1); send_data(8'h3C, 1);
    send_red();
    chk(busy === 1'b1, "R5 busy until line end", busy, 1);
    pulse_end();
    chk(busy === 1'b0, "R5 busy after line end", busy, 0);
    chk(err === 1'b0, "R9 no error on good message", err, 0);
    chk_drained("R2 code 10 strobes");

    // R3: regenerate mode, variable length, format 0xA3 -> 3 data bytes
    op_mode = 3'b111; len_code = 2'b00;
    pulse_rxdet();
    send_data(8'hA3, 1);
    send_data(8'h01, 1); send_data(8'h02, 1); send_data(8'h03, 1);
    chk(busy === 1'b1, "R3 in redundancy after 3 data", busy, 1);
    send_red();
    pulse_end();
    chk(err === 1'b0, "R3 format length matched", err, 0);
    chk_drained("R3 format 3 strobes");

    // R3: format announces zero data bytes
    pulse_rxdet();
    send_data(8'hF8, 1);
    send_red();
    pulse_end();
    chk(err === 1'b0 && busy === 1'b0, "R3 zero-length format", {err, busy}, 0);
    chk_drained("R3 zero-length strobes");

    // R9: early end during data phase
    op_mode = 3'b101; len_code = 2'b11;
    pulse_rxdet();
    send_data(8'h44, 1); send_data(8'h45, 1); send_data(8'h46, 1);
    pulse_end();
    chk(err === 1'b1, "R9 early end err", err, 1);
    chk(busy === 1'b0, "R9 early end closes message", busy, 0);
    op_mode = 3'b000;
    @(negedge clk);
    chk(bus_oe === 1'b1 && bus_out === 8'h01, "R11 status early end", {bus_oe, bus_out}, 9'h101);

    // R13 then R10: over-length message
    op_mode = 3'b101; len_code = 2'b10;
    pulse_rxdet();
    chk(err === 1'b0, "R13 err cleared at start", err, 0);
    send_data(8'h77, 1); send_data(8'h78, 1);
    send_red();
    send_red();   // extra byte: no strobe, error
    chk(err === 1'b1, "R10 over-length err", err, 1);
    chk(busy === 1'b1, "R10 busy until line end", busy, 1);
    pulse_end();
    op_mode = 3'b000;
    @(negedge clk);
    chk(bus_oe === 1'b1 && bus_out === 8'h02, "R11 status over-length", {bus_oe, bus_out}, 9'h102);
    chk_drained("R10 no strobe on extra byte");

    // R8: starts in the wrong modes are ignored
    pulse_start(); pulse_rxdet();
    chk(busy === 1'b0, "R8 status mode no start", busy, 0);
    op_mode = 3'b001;
    pulse_start(); pulse_rxdet();
    chk(busy === 1'b0, "R8 mode 001 no start", busy, 0);
    op_mode = 3'b010;
    pulse_rxdet();
    chk(busy === 1'b0, "R8 tx mode ignores rx start", busy, 0);
    op_mode = 3'b101;
    pulse_start();
    chk(busy === 1'b0, "R8 rx mode ignores start_req", busy, 0);
    send_red();
    chk(data_strobe === 1'b0 && busy === 1'b0, "R4 idle byte no strobe", {data_strobe, busy}, 0);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule